// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit turns a 16-bit offset and one of four 16-bit segment bases into a 20-bit physical byte address. The segment is shifted left by four bits and the offset is added to it. The unit holds the code, data, stack and extra segment bases. The caller states what kind of memory reference it is making, and that kind selects a default segment. An override request may replace the default, but only for plain data references. On every other kind the override is refused, the default segment is still used, and a sticky error flag is raised.

The memory side is a single byte-wide request/acknowledge channel. A byte access uses one memory cycle. A word access uses two byte cycles. The low byte goes to the lower address, and the high byte goes to the next offset, which wraps inside the 64 KB segment. Read bytes are reassembled into a 16-bit response, and a response strobe marks completion. The segment bases are written through a separate load port. Each access latches its segment base when the request is accepted.

Top module: `seg_addr_unit`

## Requirements
- R1: The memory address is (segment << 4) + offset, truncated to 20 bits. Segment 1234h with offset 0022h gives 12362h. Segment 7FA2h with offset 438Eh gives 83DAEh. Segment FFFFh with offset 0020h wraps to 00010h.
- R2: After reset the code base is FFFFh and the data, stack and extra bases are 0000h. After reset ovr_err, mem_valid and rsp_valid are 0 and req_ready is 1.
- R3: A reference of kind 0 (instruction fetch) always uses the code base.
- R4: A reference of kind 1 (stack) always uses the stack base.
- R5: A reference of kind 2 (data or string source) uses the data base when ovr_en is 0. When ovr_en is 1 it uses the base named by ovr_sel, with 0 = code, 1 = data, 2 = stack and 3 = extra, and no error is raised.
- R6: A reference of kind 3 (string destination) always uses the extra base.
- R7: A word access makes two memory cycles. The first goes to the address of the offset. The second goes to the address of (offset + 1) mod 2^16 in the same segment.
- R8: On a write, mem_we is 1. The first memory cycle carries wdata[7:0] and the second carries wdata[15:8].
- R9: A word read returns {second byte, first byte} on rsp_rdata with rsp_valid high for one cycle. A byte read returns the byte zero-extended.
- R10: ovr_err is set when a request of kind 0, 1 or 3 is accepted with ovr_en = 1. It then stays at 1 until reset. Legal overrides never set it.
- R11: While mem_valid is high and mem_ack is low, mem_addr, mem_we and mem_wdata hold their values.
- R12: When ld_en is 1 at a clock edge, ld_val is written to the base selected by ld_sel (same encoding as ovr_sel). Later requests use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Segment base write strobe |
| ld_sel | input | 2 | Segment written (0 code, 1 data, 2 stack, 3 extra) |
| ld_val | input | 16 | Segment base value |
| req_valid | input | 1 | Access request, taken when req_ready is high |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_kind | input | 2 | Reference kind (0 fetch, 1 stack, 2 data, 3 string destination) |
| req_ovr_en | input | 1 | Segment override requested |
| req_ovr_sel | input | 2 | Override segment |
| req_off | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wr | input | 1 | 1 = write |
| req_wdata | input | 16 | Write data |
| mem_valid | output | 1 | Byte memory cycle pending |
| mem_addr | output | 20 | Physical byte address |
| mem_we | output | 1 | Memory cycle is a write |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory cycle completes at this edge |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| rsp_valid | output | 1 | Access complete, one-cycle pulse |
| rsp_rdata | output | 16 | Assembled read data |
| ovr_err | output | 1 | Sticky illegal-override flag |

## Verification
The bench targets the points where address arithmetic can silently go wrong:
- A 20-bit overflow that must wrap.
- A word access at offset FFFFh, whose second byte must come from the bottom of the same segment, not from base + 10000h.
- The unit must not return the bytes swapped and must not send the high byte first.

It also issues refused overrides on the fetch, stack and destination kinds. A design that honoured them would show the overriding segment's address. A design that cleared the error flag early would lose it on the next legal access. Wait-state stalls check that a design which advanced or changed the address before the acknowledge is caught.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter int BYTE_W = 8,
  parameter logic [15:0] CS_RST = 16'hFFFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_en,
  input  logic [1:0]            ld_sel,
  input  logic [SEG_W-1:0]      ld_val,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_kind,
  input  logic                  req_ovr_en,
  input  logic [1:0]            req_ovr_sel,
  input  logic [SEG_W-1:0]      req_off,
  input  logic                  req_word,
  input  logic                  req_wr,
  input  logic [2*BYTE_W-1:0]   req_wdata,
  output logic                  mem_valid,
  output logic [SEG_W+SHIFT-1:0] mem_addr,
  output logic                  mem_we,
  output logic [BYTE_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [BYTE_W-1:0]     mem_rdata,
  output logic                  rsp_valid,
  output logic [2*BYTE_W-1:0]   rsp_rdata,
  output logic                  ovr_err
);
  localparam int AW = SEG_W + SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;

  st_t                st;
  logic [SEG_W-1:0]   seg_r [4];
  logic [SEG_W-1:0]   base_q, off_q;
  logic               word_q, wr_q;
  logic [2*BYTE_W-1:0] wd_q;
  logic [BYTE_W-1:0]  lo_q;
  logic [1:0]         sel;
  logic               illegal, accept, last_beat;

  always_comb begin
    case (req_kind)
      2'd0:    sel = 2'd0;
      2'd1:    sel = 2'd2;
      2'd2:    sel = req_ovr_en ? req_ovr_sel : 2'd1;
      default: sel = 2'd3;
    endcase
  end

  assign illegal   = req_ovr_en && (req_kind != 2'd2);
  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_valid = (st != S_IDLE);
  assign mem_addr  = {base_q, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off_q};
  assign mem_we    = mem_valid && wr_q;
  assign mem_wdata = (st == S_HI) ? wd_q[2*BYTE_W-1:BYTE_W] : wd_q[BYTE_W-1:0];
  assign last_beat = (st == S_HI) || (st == S_LO && !word_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) seg_r[i] <= (i == 0) ? CS_RST[SEG_W-1:0] : '0;
    end else if (ld_en) begin
      seg_r[ld_sel] <= ld_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      off_q     <= '0;
      word_q    <= 1'b0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      lo_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      ovr_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        st      <= S_LO;
        base_q  <= seg_r[sel];
        off_q   <= req_off;
        word_q  <= req_word;
        wr_q    <= req_wr;
        wd_q    <= req_wdata;
        if (illegal) ovr_err <= 1'b1;
      end else if (mem_valid && mem_ack) begin
        if (last_beat) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= word_q ? {mem_rdata, lo_q} : {{BYTE_W{1'b0}}, mem_rdata};
        end else begin
          st    <= S_HI;
          lo_q  <= mem_rdata;
          off_q <= off_q + 1'b1;
        end
      end
    end
  end

  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |=> ovr_err);

  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_ovr_en && req_kind != 2'd2 |=> ovr_err);

  a_r7_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_LO && word_q && mem_ack |=> mem_valid && !rsp_valid);

  a_r9_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_valid && mem_ack));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !mem_we);
endmodule

// File: tb/sim_seg_addr_unit.sv
module sim_seg_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0; logic [1:0] ld_sel = '0; logic [15:0] ld_val = '0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0; logic req_ovr_en = 1'b0; logic [1:0] req_ovr_sel = '0;
  logic [15:0] req_off = '0; logic req_word = 1'b0, req_wr = 1'b0; logic [15:0] req_wdata = '0;
  logic mem_valid, mem_we, mem_ack, rsp_valid, ovr_err;
  logic [19:0] mem_addr; logic [7:0] mem_wdata, mem_rdata; logic [15:0] rsp_rdata;
  logic ack_en = 1'b1;
  logic [15:0] sm [4];
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] patt(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
  endfunction

  assign mem_ack   = mem_valid && ack_en;
  assign mem_rdata = patt(mem_addr);

  seg_addr_unit u0 (.clk, .rst_n, .ld_en, .ld_sel, .ld_val, .req_valid, .req_ready,
    .req_kind, .req_ovr_en, .req_ovr_sel, .req_off, .req_word, .req_wr, .req_wdata,
    .mem_valid, .mem_addr, .mem_we, .mem_wdata, .mem_ack, .mem_rdata,
    .rsp_valid, .rsp_rdata, .ovr_err);

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [1:0] k, input logic oe, input logic [1:0] os);
    if (k == 2'd0) return 2'd0;
    if (k == 2'd1) return 2'd2;
    if (k == 2'd3) return 2'd3;
    return oe ? os : 2'd1;
  endfunction

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sm[0] = 16'hFFFF; sm[1] = '0; sm[2] = '0; sm[3] = '0;
    @(negedge clk);
  endtask

  task automatic load(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_val = v;
    @(negedge clk);
    ld_en = 1'b0;
    sm[s] = v;
  endtask

  task automatic run(input logic [1:0] k, input logic oe, input logic [1:0] os, input logic [15:0] off,
                     input logic wd, input logic wr, input logic [15:0] wdat, input string tag);
    logic [19:0] a [2]; logic [7:0] d [2]; logic w [2];
    logic [19:0] e0, e1; logic [15:0] sg, rd, erd;
    int n;
    bit done;
    sg = sm[exp_sel(k, oe, os)];
    e0 = {sg, 4'h0} + {4'h0, off};
    e1 = {sg, 4'h0} + {4'h0, off + 16'd1};
    n = 0; done = 0; rd = '0;
    a[0] = '0; a[1] = '0; d[0] = '0; d[1] = '0; w[0] = 0; w[1] = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_ovr_en = oe; req_ovr_sel = os;
    req_off = off; req_word = wd; req_wr = wr; req_wdata = wdat;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 40 && !done; t++) begin
      if (rsp_valid) begin
        rd = rsp_rdata; done = 1;
      end else begin
        if (mem_valid && mem_ack && n < 2) begin
          a[n] = mem_addr; d[n] = mem_wdata; w[n] = mem_we; n++;
        end
        @(negedge clk);
      end
    end
    chk(done && n == (wd ? 2 : 1), {tag, " R7 beat count"}, n, wd ? 2 : 1);
    chk(a[0] == e0, {tag, " R1 first address"}, a[0], e0);
    if (wd) chk(a[1] == e1, {tag, " R7 second address"}, a[1], e1);
    if (wr) begin
      chk(w[0] == 1'b1, {tag, " R8 write strobe"}, w[0], 1);
      chk(d[0] == wdat[7:0], {tag, " R8 low byte"}, d[0], wdat[7:0]);
      if (wd) chk(d[1] == wdat[15:8], {tag, " R8 high byte"}, d[1], wdat[15:8]);
    end else begin
      erd = wd ? {patt(e1), patt(e0)} : {8'h00, patt(e0)};
      chk(w[0] == 1'b0, {tag, " R8 read strobe"}, w[0], 0);
      chk(rd == erd, {tag, " R9 read data"}, rd, erd);
    end
  endtask

  // {kind, ovr_en, ovr_sel, offset, word, wr, wdata}
  localparam logic [38:0] VEC [8] = '{
    {2'd0, 1'b0, 2'd0, 16'h0022, 1'b0, 1'b0, 16'h0000},
    {2'd2, 1'b0, 2'd0, 16'h438E, 1'b0, 1'b0, 16'h0000},
    {2'd1, 1'b0, 2'd0, 16'h0020, 1'b1, 1'b0, 16'h0000},
    {2'd3, 1'b0, 2'd0, 16'h0005, 1'b1, 1'b1, 16'hABCD},
    {2'd2, 1'b1, 2'd3, 16'h0010, 1'b1, 1'b0, 16'h0000},
    {2'd2, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b1, 16'h005A},
    {2'd2, 1'b0, 2'd0, 16'hFFFF, 1'b1, 1'b0, 16'h0000},
    {2'd2, 1'b1, 2'd0, 16'h1000, 1'b1, 1'b1, 16'h1234}
  };

  initial begin
    logic [19:0] hold_a;
    do_reset();
    chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);
    chk(mem_valid == 1'b0, "R2 mem idle after reset", mem_valid, 0);
    chk(ovr_err == 1'b0, "R2 error clear after reset", ovr_err, 0);
    chk(rsp_valid == 1'b0, "R2 no response after reset", rsp_valid, 0);
    run(2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0, "R2 code base reset");
    run(2'd2, 1'b0, 2'd0, 16'h1234, 1'b0, 1'b0, 16'h0, "R2 data base reset");

    load(2'd0, 16'h1234); load(2'd1, 16'h7FA2);
    load(2'd2, 16'hFFFF); load(2'd3, 16'h0100);
    for (int i = 0; i < 8; i++) begin
      logic [38:0] v;
      v = VEC[i];
      run(v[38:37], v[36], v[35:34], v[33:18], v[17], v[16], v[15:0],
          $sformatf("vec%0d R3 R4 R5 R6", i));
    end
    chk(ovr_err == 1'b0, "R10 legal overrides keep flag clear", ovr_err, 0);

    load(2'd1, 16'h0BEE);
    run(2'd2, 1'b0, 2'd0, 16'h0003, 1'b1, 1'b0, 16'h0, "R12 reloaded data base");

    ack_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd2; req_ovr_en = 1'b0; req_off = 16'h0040;
    req_word = 1'b1; req_wr = 1'b1; req_wdata = 16'hC3A5;
    @(negedge clk);
    req_valid = 1'b0;
    hold_a = mem_addr;
    chk(hold_a == {16'h0BEE, 4'h0} + 20'h00040, "R11 stalled address", hold_a, 20'h0BF20);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(mem_valid && mem_addr == hold_a && mem_we && mem_wdata == 8'hA5,
          "R11 hold during stall", mem_addr, hold_a);
    end
    ack_en = 1'b1;
    for (int i = 0; i < 10 && !rsp_valid; i++) @(negedge clk);
    chk(rsp_valid == 1'b1, "R11 completes after stall", rsp_valid, 1);

    run(2'd0, 1'b1, 2'd1, 16'h0022, 1'b0, 1'b0, 16'h0, "R3 fetch override refused");
    chk(ovr_err == 1'b1, "R10 flag on fetch override", ovr_err, 1);
    run(2'd1, 1'b1, 2'd3, 16'h0002, 1'b1, 1'b0, 16'h0, "R4 stack override refused");
    run(2'd3, 1'b1, 2'd1, 16'h0007, 1'b0, 1'b1, 16'h0077, "R6 destination override refused");
    run(2'd2, 1'b0, 2'd0, 16'h0001, 1'b0, 1'b0, 16'h0, "R10 legal access after error");
    chk(ovr_err == 1'b1, "R10 flag sticky", ovr_err, 1);

    do_reset();
    chk(ovr_err == 1'b0, "R10 cleared by reset", ovr_err, 0);
    run(2'd0, 1'b0, 2'd0, 16'h0010, 1'b1, 1'b0, 16'h0, "R1 R2 fetch wraps past top");
    summary();
  end
endmodule